// File: doc/BRIEF.md
# Battery-Backed Power Mode Controller

This controller sequences the supply states of a metering microcontroller. It has three modes: normal, battery and sleep. In normal mode the switched rail takes the main supply and both the digital core domain and the analog metering domain are powered. When the main-supply-good comparator drops, the controller moves to battery mode. There the rail takes the battery and the core keeps running. The analog domain comes back on its own only while the main supply sits above its 2.75 V threshold flag and software has not set the power-down bit. From battery mode, software may ask for sleep. Sleep turns off both the core and the analog domain, and only a wake event ends it.

Every exit from sleep restarts the core from its reset vector. The controller raises a core reset pulse of a fixed length and powers the core domain at the same edge. Control state that lives in the core domain is lost in sleep and comes back at its defaults. This state is the power-down bit and the core clock select, whose default is the 1.024 MHz setting. Four 8-bit scratch registers, the low-voltage peripheral enables and the mode itself sit in the always-on domain and survive sleep. Software reaches all of them over a small register bus. Reads on this bus return data one cycle after the request.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst` the mode is normal (code 00), `sup_sel_bat`=0, `core_en`=1, `ana_en`=1, `core_rst`=0, `clk_sel` is the 1.024 MHz default (3'd2) and `periph_en` is 0.
- R2: In normal mode the rail takes the main supply and both domains are enabled. If `main_good` is low at a clock edge in normal mode, the mode is battery after that edge.
- R3: In battery mode `sup_sel_bat`=1 and `core_en`=1. `ana_en` is 1 only when `main_above_thr`=1 and the power-down bit (CTRL bit 0) is 0, and it follows these inputs with one register of delay.
- R4: A sleep request is a write to CTRL (address 0xF0) with bit 1 set and bit 7 clear. It enters sleep only from battery mode and has no effect in normal mode.
- R5: In sleep `core_en`=0, `ana_en`=0 and `sup_sel_bat`=1. The mode stays sleep, whatever `main_good` does, until `wake_evt` is high at an edge.
- R6: A wake event leaves sleep. At the same edge `core_en` rises and `core_rst` is raised for exactly 16 cycles. The new mode is normal if `main_good`=1 and battery otherwise.
- R7: The scratch registers at addresses 0xFB, 0xFC, 0xFD and 0xFE read back what was written. They keep their values through sleep and the wake reset.
- R8: The power-down bit and `clk_sel` (CTRL bits 4:2) return to 0 and 3'd2 while the core is off or in reset. A CTRL write with bit 7 set (software reset) also restores them.
- R9: A read of address 0xF1 returns the mode code in bits 1:0: 00 normal, 01 battery, 10 sleep.
- R10: Bus writes are ignored while the core is off (sleep) or held in reset.
- R11: In battery mode a high `main_good` returns the controller to normal. If this falls in the same cycle as a sleep request, the return to normal wins and sleep is not entered.
- R12: The peripheral enables at address 0xF2 (bits 3:0) drive `periph_en`. They keep their value through sleep and the wake reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| main_good | input | 1 | Main-supply-good comparator flag |
| main_above_thr | input | 1 | Main supply above the analog restart threshold |
| wake_evt | input | 1 | Wake event from the always-on peripherals |
| bus_sel | input | 1 | Register bus request |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after a read request |
| sup_sel_bat | output | 1 | Switched rail select: 0 main, 1 battery |
| core_en | output | 1 | Core digital domain enable |
| ana_en | output | 1 | Analog metering domain enable |
| core_rst | output | 1 | Core reset after wake |
| clk_sel | output | 3 | Core clock select |
| periph_en | output | 4 | Low-voltage peripheral enables |
| mode | output | 2 | Current mode code |

## Verification
The contested cycle is in battery mode: the main supply comes back in the same cycle that software writes a sleep request. The bench raises `main_good` at the negative edge where it drives the CTRL write. It then expects normal mode and both domains powered, not sleep. A second collision puts a scratch write into the first cycle of the wake reset. A later read must return the value stored before sleep. The scoreboard checks this read against its queued expectation.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_BATT   = 2'b01,
    MODE_SLEEP  = 2'b10
  } mode_t;

  localparam int ADDR_CTRL = 'hF0;
  localparam int ADDR_STAT = 'hF1;
  localparam int ADDR_PERI = 'hF2;

  localparam int CTRL_PWRDN = 0;
  localparam int CTRL_SLEEP = 1;
  localparam int CTRL_CLK_LO = 2;
  localparam int CTRL_SWRST = 7;
endpackage

// File: rtl/pmc_scratch.sv
module pmc_scratch #(
  parameter int DW  = 8,
  parameter int NUM = 4,
  localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NUM];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int RST_CYC = 16,
  localparam int CW = $clog2(RST_CYC + 1)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  main_good,
  input  logic  main_above_thr,
  input  logic  wake_evt,
  input  logic  sleep_req,
  input  logic  pwr_down,
  output mode_t state_q,
  output logic  sup_bat_q,
  output logic  core_en_q,
  output logic  ana_en_q,
  output logic  core_rst_q
);
  mode_t state_d;
  logic [CW-1:0] cnt_q;
  logic wake;

  assign wake = (state_q == MODE_SLEEP) && wake_evt;

  always_comb begin
    state_d = state_q;
    case (state_q)
      MODE_NORMAL: if (!main_good) state_d = MODE_BATT;
      MODE_BATT: begin
        if (main_good) state_d = MODE_NORMAL;
        else if (sleep_req) state_d = MODE_SLEEP;
      end
      MODE_SLEEP: if (wake_evt) state_d = main_good ? MODE_NORMAL : MODE_BATT;
      default: state_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= MODE_NORMAL;
      sup_bat_q  <= 1'b0;
      core_en_q  <= 1'b1;
      ana_en_q   <= 1'b1;
      core_rst_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      state_q   <= state_d;
      sup_bat_q <= (state_d != MODE_NORMAL);
      core_en_q <= (state_d != MODE_SLEEP);
      ana_en_q  <= (state_d == MODE_NORMAL) ||
                   ((state_d == MODE_BATT) && main_above_thr && !pwr_down);
      if (wake) begin
        core_rst_q <= 1'b1;
        cnt_q      <= CW'(RST_CYC - 1);
      end else if (core_rst_q) begin
        if (cnt_q == '0) core_rst_q <= 1'b0;
        else cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_main_loss_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_NORMAL && !main_good) |=> (state_q == MODE_BATT));
  assert_sleep_from_batt_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == MODE_SLEEP) |-> ($past(state_q) == MODE_BATT));
  assert_sleep_off_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_SLEEP) |-> (!core_en_q && !ana_en_q && sup_bat_q));
  assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_SLEEP && !wake_evt) |=> (state_q == MODE_SLEEP));
  assert_wake_reset_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_SLEEP && wake_evt) |=> (core_rst_q && core_en_q));
  assert_return_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_BATT && main_good) |=> (state_q == MODE_NORMAL));
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int NUM_SCR  = 4,
  parameter int SCR_BASE = 'hFB,
  parameter int NUM_PERI = 4,
  parameter logic [2:0] CLK_DEF = 3'd2,
  localparam int IW = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_en,
  input  logic          core_rst,
  input  mode_t         mode,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sleep_req,
  output logic          pwr_down,
  output logic [2:0]    clk_sel,
  output logic [NUM_PERI-1:0] periph_en
);
  logic wr_ok, rd_req, scr_hit, hit_ctrl, hit_peri, hit_stat, hit_scr_q;
  logic [IW-1:0] scr_idx;
  logic [DW-1:0] reg_rd_q, scr_rd;

  assign wr_ok    = bus_sel && bus_we && core_en && !core_rst;
  assign rd_req   = bus_sel && !bus_we;
  assign hit_ctrl = (int'(bus_addr) == ADDR_CTRL);
  assign hit_peri = (int'(bus_addr) == ADDR_PERI);
  assign hit_stat = (int'(bus_addr) == ADDR_STAT);
  assign scr_hit  = (int'(bus_addr) >= SCR_BASE) && (int'(bus_addr) < SCR_BASE + NUM_SCR);
  assign scr_idx  = IW'(bus_addr - AW'(SCR_BASE));
  assign sleep_req = wr_ok && hit_ctrl && bus_wdata[CTRL_SLEEP] && !bus_wdata[CTRL_SWRST];

  pmc_scratch #(.DW(DW), .NUM(NUM_SCR)) u_scr (
    .clk(clk), .we(wr_ok && scr_hit), .re(rd_req && scr_hit),
    .idx(scr_idx), .wdata(bus_wdata), .rdata(scr_rd)
  );

  // core-domain control: lost when the core is off or in reset
  always_ff @(posedge clk) begin
    if (rst || !core_en || core_rst) begin
      pwr_down <= 1'b0;
      clk_sel  <= CLK_DEF;
    end else if (wr_ok && hit_ctrl) begin
      if (bus_wdata[CTRL_SWRST]) begin
        pwr_down <= 1'b0;
        clk_sel  <= CLK_DEF;
      end else begin
        pwr_down <= bus_wdata[CTRL_PWRDN];
        clk_sel  <= bus_wdata[CTRL_CLK_LO +: 3];
      end
    end
  end

  // always-on peripheral enables
  always_ff @(posedge clk) begin
    if (rst) periph_en <= '0;
    else if (wr_ok && hit_peri) periph_en <= bus_wdata[NUM_PERI-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q  <= '0;
      hit_scr_q <= 1'b0;
    end else if (rd_req) begin
      hit_scr_q <= scr_hit;
      if (hit_ctrl)
        reg_rd_q <= DW'({clk_sel, 1'b0, pwr_down});
      else if (hit_stat)
        reg_rd_q <= DW'(mode);
      else if (hit_peri)
        reg_rd_q <= DW'(periph_en);
      else
        reg_rd_q <= '0;
    end
  end

  assign bus_rdata = hit_scr_q ? scr_rd : reg_rd_q;

  assert_ctrl_default_R8: assert property (@(posedge clk) disable iff (rst)
    (!core_en || core_rst) |=> (!pwr_down && clk_sel == CLK_DEF));
  assert_no_write_off_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && (!core_en || core_rst)) |=> $stable(periph_en));
  assert_no_sleep_req_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!core_en || core_rst) |-> !sleep_req);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int RST_CYC  = 16,
  parameter int NUM_SCR  = 4,
  parameter int SCR_BASE = 'hFB,
  parameter int NUM_PERI = 4,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter logic [2:0] CLK_DEF = 3'd2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                main_good,
  input  logic                main_above_thr,
  input  logic                wake_evt,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                sup_sel_bat,
  output logic                core_en,
  output logic                ana_en,
  output logic                core_rst,
  output logic [2:0]          clk_sel,
  output logic [NUM_PERI-1:0] periph_en,
  output logic [1:0]          mode
);
  mode_t state;
  logic  sleep_req, pwr_down;

  pmc_fsm #(.RST_CYC(RST_CYC)) u_fsm (
    .clk(clk), .rst(rst), .main_good(main_good),
    .main_above_thr(main_above_thr), .wake_evt(wake_evt),
    .sleep_req(sleep_req), .pwr_down(pwr_down), .state_q(state),
    .sup_bat_q(sup_sel_bat), .core_en_q(core_en), .ana_en_q(ana_en),
    .core_rst_q(core_rst)
  );

  pmc_regs #(
    .AW(AW), .DW(DW), .NUM_SCR(NUM_SCR), .SCR_BASE(SCR_BASE),
    .NUM_PERI(NUM_PERI), .CLK_DEF(CLK_DEF)
  ) u_regs (
    .clk(clk), .rst(rst), .core_en(core_en), .core_rst(core_rst),
    .mode(state), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sleep_req(sleep_req), .pwr_down(pwr_down), .clk_sel(clk_sel),
    .periph_en(periph_en)
  );

  assign mode = state;

  assert_rail_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (sup_sel_bat && core_en));
  assert_normal_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> (!sup_sel_bat && core_en && ana_en));
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic clk = 0, rst = 1;
  logic main_good = 1, main_above_thr = 1, wake_evt = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic sup_sel_bat, core_en, ana_en, core_rst;
  logic [2:0] clk_sel;
  logic [3:0] periph_en;
  logic [1:0] mode;
  int total = 0, bad = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];
  logic rv = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl uut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = 8'(a); bus_wdata = 8'(d);
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(int a, int exp, string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = 8'(a);
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare each read result against the scoreboard queue
  always @(posedge clk) rv <= bus_sel && !bus_we;
  always @(negedge clk) begin
    if (rv) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else chk(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
    end
  end

  task automatic wake_and_count(int exp_mode);
    int n = 0;
    @(negedge clk); wake_evt = 1;
    @(negedge clk); wake_evt = 0;
    chk("R6 core_en with reset", int'(core_en), 1);
    chk("R6 mode after wake", int'(mode), exp_mode);
    while (core_rst && n < 100) begin n++; @(negedge clk); end
    chk("R6 reset length", n, 16);
  endtask

  initial begin
    cyc(3); rst = 0; cyc(1);
    chk("R1 mode", int'(mode), 0);
    chk("R1 sup", int'(sup_sel_bat), 0);
    chk("R1 core_en", int'(core_en), 1);
    chk("R1 ana_en", int'(ana_en), 1);
    chk("R1 core_rst", int'(core_rst), 0);
    chk("R1 clk_sel", int'(clk_sel), 2);
    chk("R1 periph", int'(periph_en), 0);
    rd('hF1, 0, "R9 status normal");

    wr('hFB, 'hA5); wr('hFC, 'h5A); wr('hFD, 'h3C); wr('hFE, 'hC3);
    rd('hFB, 'hA5, "R7 scratch0"); rd('hFE, 'hC3, "R7 scratch3");
    wr('hF2, 'h0B); chk("R12 periph_en", int'(periph_en), 'hB);
    wr('hF0, 'h14); chk("R8 clk_sel write", int'(clk_sel), 5);
    rd('hF0, 'h14, "R8 ctrl readback");
    wr('hF0, 'h80); chk("R8 soft reset", int'(clk_sel), 2);

    wr('hF0, 'h02); cyc(1);
    chk("R4 no sleep from normal", int'(mode), 0);

    main_good = 0; cyc(1);
    chk("R2 to battery", int'(mode), 1);
    chk("R3 sup battery", int'(sup_sel_bat), 1);
    chk("R3 core_en", int'(core_en), 1);
    chk("R3 ana_en on", int'(ana_en), 1);
    rd('hF1, 1, "R9 status battery");
    main_above_thr = 0; cyc(1);
    chk("R3 ana_en below thr", int'(ana_en), 0);
    main_above_thr = 1; cyc(1);
    chk("R3 ana_en back", int'(ana_en), 1);
    wr('hF0, 'h01); cyc(1);
    chk("R3 ana_en pwrdn", int'(ana_en), 0);
    wr('hF0, 'h14); cyc(1);
    chk("R3 ana_en pwrdn clear", int'(ana_en), 1);

    wr('hF0, 'h02);
    chk("R4 sleep from battery", int'(mode), 2);
    chk("R5 core off", int'(core_en), 0);
    chk("R5 ana off", int'(ana_en), 0);
    chk("R5 battery rail", int'(sup_sel_bat), 1);
    wr('hFB, 'h11); wr('hF2, 'h04);
    chk("R10 periph unchanged in sleep", int'(periph_en), 'hB);
    main_good = 1; cyc(3);
    chk("R5 stays asleep", int'(mode), 2);
    main_good = 0; cyc(1);

    wake_and_count(1);
    chk("R8 clk_sel default after wake", int'(clk_sel), 2);
    chk("R12 periph retained", int'(periph_en), 'hB);
    rd('hFB, 'hA5, "R10 R7 scratch0 retained");
    rd('hFC, 'h5A, "R7 scratch1 retained");
    rd('hFD, 'h3C, "R7 scratch2 retained");
    rd('hFE, 'hC3, "R7 scratch3 retained");

    // main supply returns in the cycle of a sleep request
    @(negedge clk); main_good = 1; bus_sel = 1; bus_we = 1;
    bus_addr = 8'hF0; bus_wdata = 8'h02;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    chk("R11 return wins", int'(mode), 0);
    chk("R11 core on", int'(core_en), 1);
    cyc(2);
    chk("R11 no late sleep", int'(mode), 0);

    main_good = 0; cyc(1);
    wr('hF0, 'h02);
    chk("R4 sleep again", int'(mode), 2);
    main_good = 1;
    @(negedge clk); wake_evt = 1;
    @(negedge clk); wake_evt = 0; bus_sel = 1; bus_we = 1;
    bus_addr = 8'hFC; bus_wdata = 8'h77;
    chk("R6 wake to normal", int'(mode), 0);
    chk("R6 reset raised", int'(core_rst), 1);
    @(negedge clk); bus_sel = 0; bus_we = 0;
    cyc(16);
    chk("R6 reset released", int'(core_rst), 0);
    rd('hFC, 'h5A, "R10 write in reset ignored");
    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule